// File: doc/BRIEF.md
# Debug Breakpoint Status and Configuration Register

This block is a 32-bit configuration and status word for a processor debug unit. It runs a small two-level hardware breakpoint sequencer and shows its state in a 4-bit status field. It keeps sticky flags recording why the core entered debug mode, and it holds three control bits. The breakpoint comparators sit outside the block. They deliver enable levels and single-cycle match pulses. The debug-mode entry logic delivers single-cycle cause pulses and a GO (resume) pulse.

Access is asymmetric. The CPU may only write the word, and only while it runs in supervisor mode. The debug port may both read and write it. Only the control bits take writes. The status field is cleared in three ways:
- a write to the trigger-definition register (any variant);
- a debug-port read after the final breakpoint level has fired;
- the breakpoint enable being dropped.

The status field is also driven onto a separate trace output, which the trace multiplexer shows whenever it has nothing else to send.

Top module: `dbg_cfgstat_reg`

## Requirements
- R1: After reset the word reads 0x00B00000: the revision field is 1011 and every other bit is 0.
- R2: The read word is laid out as follows:
  - [31:28] status
  - [27] fault-on-fault flag
  - [26] hardware-trigger flag
  - [25] halt-instruction flag
  - [24] breakpoint-pin flag
  - [23:20] revision
  - [18:16] control
  - bit 19 and bits [15:0] always read 0.
- R3: The status field moves from 0000 (none enabled) to 0001 (waiting on level 1) one cycle after the level-1 enable is high. Dropping the level-1 enable while the field is 0001 or 0101 returns it to 0000.
- R4: The level-1 match takes effect only while the field is 0001.
  - With the level-2 enable low, a level-1 match gives 0010 (level 1 triggered).
  - With the level-2 enable high, a level-1 match gives 0101 (waiting on level 2).
  - From 0101, a level-2 match gives 0110 (level 2 triggered).
  - 0010 and 0110 hold until they are cleared.
  - No other code ever appears.
- R5: A trigger-definition write strobe sets the status field to 0000 in the next cycle.
- R6: A debug-port read returns the current word. It clears the status field in the next cycle only in two cases: the field is 0110, or the field is 0010 with the level-2 enable low. In any other state the read leaves the field unchanged.
- R7: When a clear event (R5 or R6) and a match transition (R4) fall in the same cycle, the match transition wins.
- R8: The hardware-trigger, halt-instruction and breakpoint-pin flags are each set by their own cause pulse. GO clears all three. A set pulse in the same cycle as GO wins.
- R9: The fault-on-fault flag is set by a catastrophic-halt pulse. Only reset clears it, and GO leaves it set.
- R10: The control bits [18:16] are loaded in the following cases:
  - a CPU write while the supervisor input is high;
  - any debug-port write.
  
  A CPU write without supervisor mode changes nothing. When both sides write in the same cycle, the debug-port data wins.
- R11: Writes from either side leave the status, flag and revision bits unchanged.
- R12: The trace status output always equals bits [31:28] of the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU-side write strobe |
| cpu_sup | input | 1 | CPU is in supervisor mode |
| cpu_wdata | input | 32 | CPU-side write data |
| dp_wr | input | 1 | Debug-port write strobe |
| dp_rd | input | 1 | Debug-port read strobe |
| dp_wdata | input | 32 | Debug-port write data |
| dp_rdata | output | 32 | Register word as read by the debug port |
| tdr_wr | input | 1 | Write strobe of the trigger-definition register (any variant) |
| l1_en | input | 1 | Level-1 breakpoint enabled |
| l2_en | input | 1 | Level-2 breakpoint enabled |
| l1_hit | input | 1 | Level-1 match pulse |
| l2_hit | input | 1 | Level-2 match pulse |
| cause_fof | input | 1 | Catastrophic-halt entry pulse |
| cause_trg | input | 1 | Hardware-trigger entry pulse |
| cause_halt | input | 1 | Halt-instruction entry pulse |
| cause_pin | input | 1 | Breakpoint-pin entry pulse |
| go_cmd | input | 1 | GO command pulse |
| trace_bstat | output | 4 | Status field for the trace port |
| ctrl_out | output | 3 | Control bits |

## Verification
A wrong sequencer state shows up as a wrong code in bits [31:28] and on the trace output. It becomes visible one clock edge after the event that caused it. A reserved code, a missed clear or a lost priority is therefore caught at the first read that follows.

A bad flag or control update appears in the read word one cycle after the pulse or write. A GO that wrongly clears the fault-on-fault flag stays visible on every later read until the next reset.

// File: rtl/dbg_csr_pkg.sv
package dbg_csr_pkg;
  localparam int WORD_W   = 32;
  localparam int POS_BST  = 28;
  localparam int POS_FLAG = 24;
  localparam int POS_REV  = 20;
  localparam int POS_CTRL = 16;
  localparam int CTRL_W   = 3;
  localparam int FLAG_N   = 4;

  typedef enum logic [3:0] {
    BST_OFF   = 4'b0000,
    BST_WAIT1 = 4'b0001,
    BST_HIT1  = 4'b0010,
    BST_WAIT2 = 4'b0101,
    BST_HIT2  = 4'b0110
  } bstat_e;

  function automatic logic read_clears(bstat_e cur, logic lvl2_en);
    return (cur == BST_HIT2) || (cur == BST_HIT1 && !lvl2_en);
  endfunction

  function automatic bstat_e bstat_next(bstat_e cur, logic e1, logic e2,
                                        logic h1, logic h2, logic clr);
    bstat_e n;
    n = cur;
    case (cur)
      BST_OFF:   n = (e1 && !clr) ? BST_WAIT1 : BST_OFF;
      BST_WAIT1: if (!e1) n = BST_OFF;
                 else if (h1) n = e2 ? BST_WAIT2 : BST_HIT1;
                 else if (clr) n = BST_OFF;
      BST_WAIT2: if (!e1) n = BST_OFF;
                 else if (h2) n = BST_HIT2;
                 else if (clr) n = BST_OFF;
      BST_HIT1,
      BST_HIT2:  if (clr) n = BST_OFF;
      default:   n = BST_OFF;
    endcase
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(bstat_e st,
      logic [FLAG_N-1:0] fl, logic [3:0] rev, logic [CTRL_W-1:0] ct);
    logic [WORD_W-1:0] w;
    w = '0;
    w[POS_BST +: 4]       = st;
    w[POS_FLAG +: FLAG_N] = fl;
    w[POS_REV +: 4]       = rev;
    w[POS_CTRL +: CTRL_W] = ct;
    return w;
  endfunction
endpackage

// File: rtl/dbg_bstat_seq.sv
module dbg_bstat_seq
  import dbg_csr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   l1_en,
  input  logic   l2_en,
  input  logic   l1_hit,
  input  logic   l2_hit,
  input  logic   tdr_wr,
  input  logic   dp_rd,
  output bstat_e bstat,
  output logic   clr_evt
);
  bstat_e bstat_q;

  assign clr_evt = tdr_wr || (dp_rd && read_clears(bstat_q, l2_en));

  always_ff @(posedge clk) begin
    if (!rst_n) bstat_q <= BST_OFF;
    else        bstat_q <= bstat_next(bstat_q, l1_en, l2_en, l1_hit, l2_hit, clr_evt);
  end

  assign bstat = bstat_q;
endmodule

// File: rtl/dbg_cause_flags.sv
module dbg_cause_flags #(
  parameter int N = 4,
  parameter logic [N-1:0] GO_CLR_MASK = 4'b0111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         go_cmd,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        q <= 1'b0;
      else if (set[i])                   q <= 1'b1;
      else if (go_cmd && GO_CLR_MASK[i]) q <= 1'b0;
    end
    assign flags[i] = q;
  end
endmodule

// File: rtl/dbg_ctrl_bits.sv
module dbg_ctrl_bits #(
  parameter int WORD_W = 32,
  parameter int LSB    = 16,
  parameter int W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_sup,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic              dp_wr,
  input  logic [WORD_W-1:0] dp_wdata,
  output logic [W-1:0]      ctrl
);
  logic cpu_ok;
  assign cpu_ok = cpu_wr && cpu_sup;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl <= '0;
    else if (dp_wr)  ctrl <= dp_wdata[LSB +: W];
    else if (cpu_ok) ctrl <= cpu_wdata[LSB +: W];
  end
endmodule

// File: rtl/dbg_cfgstat_reg.sv
module dbg_cfgstat_reg
  import dbg_csr_pkg::*;
#(
  parameter logic [3:0] REV_LEVEL = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_sup,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic              dp_wr,
  input  logic              dp_rd,
  input  logic [WORD_W-1:0] dp_wdata,
  output logic [WORD_W-1:0] dp_rdata,
  input  logic              tdr_wr,
  input  logic              l1_en,
  input  logic              l2_en,
  input  logic              l1_hit,
  input  logic              l2_hit,
  input  logic              cause_fof,
  input  logic              cause_trg,
  input  logic              cause_halt,
  input  logic              cause_pin,
  input  logic              go_cmd,
  output logic [3:0]        trace_bstat,
  output logic [CTRL_W-1:0] ctrl_out
);
  bstat_e            bstat;
  logic              clr_evt;
  logic [FLAG_N-1:0] cause_set;
  logic [FLAG_N-1:0] cause_flags;

  assign cause_set = {cause_fof, cause_trg, cause_halt, cause_pin};

  dbg_bstat_seq u_seq (
    .clk(clk), .rst_n(rst_n), .l1_en(l1_en), .l2_en(l2_en),
    .l1_hit(l1_hit), .l2_hit(l2_hit), .tdr_wr(tdr_wr), .dp_rd(dp_rd),
    .bstat(bstat), .clr_evt(clr_evt)
  );

  dbg_cause_flags #(.N(FLAG_N), .GO_CLR_MASK(4'b0111)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(cause_set), .go_cmd(go_cmd),
    .flags(cause_flags)
  );

  dbg_ctrl_bits #(.WORD_W(WORD_W), .LSB(POS_CTRL), .W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sup(cpu_sup),
    .cpu_wdata(cpu_wdata), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
    .ctrl(ctrl_out)
  );

  assign dp_rdata    = pack_word(bstat, cause_flags, REV_LEVEL, ctrl_out);
  assign trace_bstat = bstat;
endmodule

// File: rtl/dbg_cfgstat_reg_chk.sv
module dbg_cfgstat_reg_chk
  import dbg_csr_pkg::*;
#(
  parameter logic [3:0] REV_LEVEL = 4'b1011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic              cpu_sup,
  input logic              dp_wr,
  input logic              dp_rd,
  input logic              tdr_wr,
  input logic              l1_en,
  input logic              l1_hit,
  input logic              l2_hit,
  input logic              go_cmd,
  input logic [FLAG_N-1:0] cause_set,
  input logic [WORD_W-1:0] dp_rdata,
  input logic [3:0]        trace_bstat,
  input logic              clr_evt
);
  logic [3:0] st;
  assign st = dp_rdata[31:28];

  assert_bstat_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st inside {4'b0000, 4'b0001, 4'b0010, 4'b0101, 4'b0110});

  assert_tdr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tdr_wr && st inside {4'b0010, 4'b0110}) |=> st == 4'b0000);

  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd && st == 4'b0110) |=> st == 4'b0000);

  assert_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && st == 4'b0001 && l1_en && l1_hit) |=> st != 4'b0000);

  assert_go_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cmd && cause_set[2:0] == 3'b000) |=> dp_rdata[26:24] == 3'b000);

  assert_fof_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rdata[27] |=> dp_rdata[27]);

  assert_cpu_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_sup && !dp_wr) |=> $stable(dp_rdata[18:16]));

  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rdata[23:20] == REV_LEVEL && !dp_rdata[19] && dp_rdata[15:0] == 16'h0);

  assert_trace_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trace_bstat == st);

  assert_wr_no_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_wr || dp_wr) && !clr_evt && !l1_hit && !l2_hit && !go_cmd
     && cause_set == '0 && st inside {4'b0010, 4'b0110})
    |=> $stable(dp_rdata[31:24]));
endmodule

bind dbg_cfgstat_reg dbg_cfgstat_reg_chk #(.REV_LEVEL(REV_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sup(cpu_sup),
  .dp_wr(dp_wr), .dp_rd(dp_rd), .tdr_wr(tdr_wr), .l1_en(l1_en),
  .l1_hit(l1_hit), .l2_hit(l2_hit), .go_cmd(go_cmd), .cause_set(cause_set),
  .dp_rdata(dp_rdata), .trace_bstat(trace_bstat), .clr_evt(clr_evt)
);

// File: tb/dbg_cfgstat_reg_bench.sv
module dbg_cfgstat_reg_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] MS = 32'hF000_0000;
  localparam logic [31:0] MF = 32'h0F00_0000;
  localparam logic [31:0] MC = 32'h0007_0000;
  localparam logic [31:0] MA = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 0, cpu_sup = 0, dp_wr = 0, dp_rd = 0, tdr_wr = 0;
  logic [31:0] cpu_wdata = '0, dp_wdata = '0;
  logic l1_en = 0, l2_en = 0, l1_hit = 0, l2_hit = 0;
  logic cause_fof = 0, cause_trg = 0, cause_halt = 0, cause_pin = 0, go_cmd = 0;
  logic [31:0] dp_rdata;
  logic [3:0]  trace_bstat;
  logic [2:0]  ctrl_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  string       tq[$];
  logic [31:0] mq[$];
  logic [31:0] eq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cfgstat_reg u_dbg_cfgstat_reg (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sup(cpu_sup),
    .cpu_wdata(cpu_wdata), .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wdata(dp_wdata),
    .dp_rdata(dp_rdata), .tdr_wr(tdr_wr), .l1_en(l1_en), .l2_en(l2_en),
    .l1_hit(l1_hit), .l2_hit(l2_hit), .cause_fof(cause_fof),
    .cause_trg(cause_trg), .cause_halt(cause_halt), .cause_pin(cause_pin),
    .go_cmd(go_cmd), .trace_bstat(trace_bstat), .ctrl_out(ctrl_out)
  );

  // monitor: pops expected items and compares them against the outputs
  always @(negedge clk) begin
    if (mq.size() > 0) begin
      string t;
      logic [31:0] m, e;
      t = tq.pop_front();
      m = mq.pop_front();
      e = eq.pop_front();
      checks++;
      if ((dp_rdata & m) !== (e & m)) begin
        failures++;
        $display("FAIL %s: rdata=%h expected=%h (mask %h)", t, dp_rdata & m, e & m, m);
      end
      if (m[31:28] == 4'hF) begin
        checks++;
        if (trace_bstat !== e[31:28]) begin
          failures++;
          $display("FAIL R12 (%s): trace=%h expected=%h", t, trace_bstat, e[31:28]);
        end
      end
      if (m[18:16] == 3'b111) begin
        checks++;
        if (ctrl_out !== e[18:16]) begin
          failures++;
          $display("FAIL R10 (%s): ctrl_out=%h expected=%h", t, ctrl_out, e[18:16]);
        end
      end
    end
  end

  // driver: one clock with the current inputs, then queue the expected word
  task automatic tick(input string tag, input logic [31:0] m, input logic [31:0] e);
    @(posedge clk);
    tq.push_back(tag); mq.push_back(m); eq.push_back(e);
    @(negedge clk);
    cpu_wr = 0; dp_wr = 0; dp_rd = 0; tdr_wr = 0; l1_hit = 0; l2_hit = 0;
    cause_fof = 0; cause_trg = 0; cause_halt = 0; cause_pin = 0; go_cmd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick("R1 reset word", MA, 32'h00B0_0000);

    // two-level sequencer, level 2 off
    l1_en = 1;
    tick("R3 arm", MS, 32'h1000_0000);
    l1_hit = 1;
    tick("R4 l1 hit, l2 off", MS, 32'h2000_0000);
    tick("R4 hold hit1", MS, 32'h2000_0000);
    dp_rd = 1;
    tick("R6 read clears hit1", MS, 32'h0000_0000);
    tick("R3 rearm", MS, 32'h1000_0000);

    // level 2 armed
    l2_en = 1; l1_hit = 1;
    tick("R4 l1 hit, l2 on", MS, 32'h5000_0000);
    dp_rd = 1;
    tick("R6 read keeps wait2", MS, 32'h5000_0000);
    l2_hit = 1;
    tick("R4 l2 hit", MS, 32'h6000_0000);
    tick("R4 hold hit2", MS, 32'h6000_0000);
    dp_rd = 1;
    tick("R6 read clears hit2", MS, 32'h0000_0000);
    tick("R3 rearm 2", MS, 32'h1000_0000);
    tdr_wr = 1;
    tick("R5 tdr clears wait1", MS, 32'h0000_0000);
    tick("R3 rearm 3", MS, 32'h1000_0000);

    // same-cycle clear and match
    tdr_wr = 1; l1_hit = 1;
    tick("R7 l1 hit beats tdr", MS, 32'h5000_0000);
    tdr_wr = 1; l2_hit = 1;
    tick("R7 l2 hit beats tdr", MS, 32'h6000_0000);
    tdr_wr = 1;
    tick("R5 tdr clears hit2", MS, 32'h0000_0000);
    tick("R3 rearm 4", MS, 32'h1000_0000);
    l1_en = 0;
    tick("R3 disarm", MS, 32'h0000_0000);

    // hit1 with level 2 enabled later: read does not clear
    l1_en = 1; l2_en = 0;
    tick("R3 arm again", MS, 32'h1000_0000);
    l1_hit = 1;
    tick("R4 hit1 again", MS, 32'h2000_0000);
    l2_en = 1; dp_rd = 1;
    tick("R6 read keeps hit1 with l2 on", MS, 32'h2000_0000);
    tdr_wr = 1;
    tick("R5 tdr clears hit1", MS, 32'h0000_0000);
    l1_en = 0; l2_en = 0;
    tick("R3 stays off", MS, 32'h0000_0000);

    // cause flags
    cause_trg = 1;
    tick("R8 trg flag", MF, 32'h0400_0000);
    cause_halt = 1;
    tick("R8 halt flag", MF, 32'h0600_0000);
    cause_pin = 1;
    tick("R8 pin flag", MF, 32'h0700_0000);
    cause_fof = 1;
    tick("R9 fof flag", MF, 32'h0F00_0000);
    go_cmd = 1;
    tick("R8 R9 go clears three, keeps fof", MF, 32'h0800_0000);
    go_cmd = 1; cause_halt = 1;
    tick("R8 set beats go", MF, 32'h0A00_0000);
    go_cmd = 1;
    tick("R8 go clears halt", MF, 32'h0800_0000);

    // control bits
    cpu_wr = 1; cpu_sup = 1; cpu_wdata = 32'h0005_0000;
    tick("R10 cpu supervisor write", MC, 32'h0005_0000);
    cpu_wr = 1; cpu_sup = 0; cpu_wdata = 32'h0002_0000;
    tick("R10 cpu user write dropped", MC, 32'h0005_0000);
    dp_wr = 1; dp_wdata = 32'h0003_0000;
    tick("R10 dp write", MC, 32'h0003_0000);
    cpu_wr = 1; cpu_sup = 1; cpu_wdata = 32'h0001_0000;
    dp_wr = 1; dp_wdata = 32'h0006_0000;
    tick("R10 dp wins", MC, 32'h0006_0000);

    // read-only bits
    dp_wr = 1; dp_wdata = 32'hFFFF_FFFF;
    tick("R11 R2 dp all-ones write", MA, 32'h08B7_0000);
    cpu_wr = 1; cpu_sup = 1; cpu_wdata = 32'h0000_0000;
    tick("R11 R2 cpu zero write", MA, 32'h08B0_0000);
    l1_en = 1; l2_en = 0;
    tick("R2 arm for layout", MS, 32'h1000_0000);
    l1_hit = 1;
    tick("R2 hit1 for layout", MS, 32'h2000_0000);
    dp_wr = 1; dp_wdata = 32'h0000_0000;
    cpu_wr = 1; cpu_sup = 1; cpu_wdata = 32'hF7FF_FFFF;
    tick("R11 R2 writes leave hit1", MA, 32'h28B0_0000);

    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule